// File: doc/BRIEF.md
# CPU Data Port Control for a Pipe Buffer

This block sits between a host processor and the buffer of one selected endpoint pipe in a USB device controller. The processor selects a pipe, its access width and its length-reporting mode through a configuration write. It then reads one 16-bit control word that shows whether the data port may be used, whether a transmit packet is committed, and how many received bytes remain. Writing the same word commits a transmit packet or empties the buffer.

Pipe 0 is the bidirectional default control pipe. For this pipe, a configuration bit picks the direction. Every other pipe takes its direction from a static per-pipe map. A small status interface carries the buffer model's fill level, free-space flag and newly arrived packet lengths. The block drives clear and commit strobes back to the buffer model.

Top module: `cfifo_port_ctrl`

## Requirements
- R1: Control word layout: bit 15 is buffer-valid, bit 14 is the clear strobe and always reads 0, bit 13 is port-ready, bits 12..10 read 0, and bits 9..0 hold the receive length. A synchronous reset sets every register, including the configuration, to 0.
- R2: The pipe direction is receive when `cfg_pipe` is 0 and the select bit is 1. For any other pipe number p, the direction is receive when `pipe_is_rx[p]` is 1. In every other case it is transmit.
- R3: Port-ready is 0 for the two clocks that follow a configuration write or an accepted clear. After that it equals (`buf_bytes` != 0) for a receive pipe and `buf_room` for a transmit pipe.
- R4: A control write with bit 14 = 1 is accepted while port-ready is 1, or at any time on pipe 0. An accepted clear gives a one-cycle `buf_clr` pulse on the next clock, and `buf_clr_isel` carries the select bit. A write with bit 14 = 0 clears nothing.
- R5: Writing 1 to bit 15 sets buffer-valid and pulses `buf_commit` on the next clock. This is refused on a transmit pipe whose buffer-valid bit is already 1. Writing 0 to bit 15 leaves buffer-valid unchanged.
- R6: On a transmit pipe in non-continuous mode (`cfg_cont` = 0), buffer-valid sets when `buf_bytes` >= `max_pkt` and `max_pkt` is nonzero.
- R7: Buffer-valid clears when `buf_bytes` drops from nonzero to 0, and when a clear is accepted. A clear takes priority over any set in the same cycle.
- R8: With count mode on (`cfg_cnt` = 1), each counted data read lowers the length by 1 in 8-bit width. In 16-bit width (`cfg_wide` = 1) it lowers the length by 2, or by 1 when only one byte is left. The length never goes below 0.
- R9: With count mode off, the length keeps its loaded value while reads proceed. It becomes 0 once all loaded bytes have been read.
- R10: Bits 9..0 read as 0 whenever the current pipe direction is transmit.
- R11: A `dp_rd` pulse is counted only while port-ready is 1 and the pipe direction is receive.
- R12: `rx_load` loads `rx_len` as the new length. Without a load, the remaining count never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_pipe | input | 3 | Selected pipe number |
| cfg_isel | input | 1 | Pipe 0 direction select, 1 = receive |
| cfg_cnt | input | 1 | Length count-down mode |
| cfg_wide | input | 1 | 1 = 16-bit data access |
| cfg_cont | input | 1 | 1 = continuous transfer mode |
| pipe_is_rx | input | 8 | Receive-direction map for pipes 1..7 (bit 0 unused) |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word write value |
| ctl_rdata | output | 16 | Control word read value |
| dp_rd | input | 1 | Data port read strobe |
| max_pkt | input | 10 | Maximum packet size of the current pipe |
| rx_load | input | 1 | Received packet available |
| rx_len | input | 10 | Length of that received packet |
| buf_bytes | input | 10 | Bytes held in the current buffer |
| buf_room | input | 1 | Current buffer has free space |
| buf_clr | output | 1 | Buffer clear pulse |
| buf_clr_isel | output | 1 | Select bit that came with the last clear |
| buf_commit | output | 1 | Transmit commit pulse |

## Verification
The bench aims at the last odd byte in 16-bit count-down mode. A design without saturation would wrap the length to 1023 there. It also holds the held length in non-counting mode across partial and full drains: a wrong design would show a stale value or clear too early. Clears are tried on a pipe that is not ready, where a wrong design would empty a busy buffer, and on pipe 0 while not ready, where the clear must still go through. The bench also repeats a commit on a transmit pipe that already holds a valid packet, which must produce no second strobe. Finally, it checks that the length reads as zero while a transmit pipe is selected and returns when the direction flips.

// File: rtl/cfp_pkg.sv
package cfp_pkg;
  localparam int PIPE_W    = 3;
  localparam int WORD_W    = 16;
  localparam int BIT_VALID = 15;
  localparam int BIT_CLR   = 14;
  localparam int BIT_RDY   = 13;

  typedef struct packed {
    logic [PIPE_W-1:0] pipe;
    logic              isel;
    logic              cnt;
    logic              wide;
    logic              cont;
  } cfg_t;
endpackage

// File: rtl/cfp_settle.sv
module cfp_settle #(
  parameter int SETTLE = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic cond,
  output logic rdy
);
  localparam int SW = $clog2(SETTLE + 1);

  logic [SW-1:0] cnt_q;
  logic          rdy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else begin
      if (start)
        cnt_q <= SW'(SETTLE);
      else if (cnt_q != '0)
        cnt_q <= cnt_q - 1'b1;
      rdy_q <= !start && (cnt_q <= SW'(1)) && cond;
    end
  end

  assign rdy = rdy_q;

  assert_settle_blank_R3: assert property (@(posedge clk) disable iff (rst)
    start |=> !rdy_q);
endmodule

// File: rtl/cfp_bval.sv
module cfp_bval (
  input  logic clk,
  input  logic rst,
  input  logic wr_one,
  input  logic is_tx,
  input  logic full,
  input  logic empty_now,
  input  logic clr,
  output logic valid,
  output logic commit
);
  logic valid_q, commit_q, nz_q, commit_ok, drained;

  assign commit_ok = wr_one && !(is_tx && valid_q);
  assign drained   = nz_q && empty_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= 1'b0;
      commit_q <= 1'b0;
      nz_q     <= 1'b0;
    end else begin
      nz_q     <= !empty_now;
      commit_q <= commit_ok && !clr;
      if (clr)
        valid_q <= 1'b0;
      else if (commit_ok || full)
        valid_q <= 1'b1;
      else if (drained)
        valid_q <= 1'b0;
    end
  end

  assign valid  = valid_q;
  assign commit = commit_q;

  assert_clr_drops_valid_R7: assert property (@(posedge clk) disable iff (rst)
    clr |=> !valid_q);
  assert_block_recommit_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_one && is_tx && valid_q) |=> !commit_q);
  assert_commit_sets_R5: assert property (@(posedge clk) disable iff (rst)
    commit_q |-> valid_q);
endmodule

// File: rtl/cfp_rxlen.sv
module cfp_rxlen #(
  parameter int LW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [LW-1:0] load_len,
  input  logic          rd,
  input  logic          wide,
  input  logic          cnt,
  input  logic          clr,
  output logic [LW-1:0] len_view
);
  logic [LW-1:0] rem_q, hold_q, step;

  assign step = (wide && rem_q > LW'(1)) ? LW'(2) : LW'(1);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      rem_q  <= '0;
      hold_q <= '0;
    end else if (load) begin
      rem_q  <= load_len;
      hold_q <= load_len;
    end else if (rd && rem_q != '0) begin
      rem_q <= rem_q - step;
    end
  end

  assign len_view = cnt ? rem_q : ((rem_q == '0) ? '0 : hold_q);

  assert_wide_step_R8: assert property (@(posedge clk) disable iff (rst)
    (rd && wide && rem_q > LW'(1) && !load && !clr) |=> (rem_q == $past(rem_q) - LW'(2)));
  assert_no_rise_R12: assert property (@(posedge clk) disable iff (rst)
    !load |=> (rem_q <= $past(rem_q)));
endmodule

// File: rtl/cfifo_port_ctrl.sv
module cfifo_port_ctrl
  import cfp_pkg::*;
#(
  parameter int PIPES  = 8,
  parameter int LW     = 10,
  parameter int SETTLE = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_wr,
  input  logic [PIPE_W-1:0]      cfg_pipe,
  input  logic                   cfg_isel,
  input  logic                   cfg_cnt,
  input  logic                   cfg_wide,
  input  logic                   cfg_cont,
  input  logic [PIPES-1:0]       pipe_is_rx,
  input  logic                   ctl_wr,
  input  logic [WORD_W-1:0]      ctl_wdata,
  output logic [WORD_W-1:0]      ctl_rdata,
  input  logic                   dp_rd,
  input  logic [LW-1:0]          max_pkt,
  input  logic                   rx_load,
  input  logic [LW-1:0]          rx_len,
  input  logic [LW-1:0]          buf_bytes,
  input  logic                   buf_room,
  output logic                   buf_clr,
  output logic                   buf_clr_isel,
  output logic                   buf_commit
);
  localparam int PAD_W = BIT_RDY - LW;

  cfg_t          cfg_q;
  logic          rx_dir, rdy, valid, clr_acc, rd_acc, cond, full;
  logic          clr_q, clr_isel_q;
  logic [LW-1:0] len_view;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q      <= '0;
      clr_q      <= 1'b0;
      clr_isel_q <= 1'b0;
    end else begin
      if (cfg_wr)
        cfg_q <= '{pipe: cfg_pipe, isel: cfg_isel, cnt: cfg_cnt,
                   wide: cfg_wide, cont: cfg_cont};
      clr_q <= clr_acc;
      if (clr_acc)
        clr_isel_q <= cfg_q.isel;
    end
  end

  assign rx_dir  = (cfg_q.pipe == '0) ? cfg_q.isel : pipe_is_rx[cfg_q.pipe];
  assign clr_acc = ctl_wr && ctl_wdata[BIT_CLR] && ((cfg_q.pipe == '0) || rdy);
  assign rd_acc  = dp_rd && rdy && rx_dir;
  assign cond    = rx_dir ? (buf_bytes != '0) : buf_room;
  assign full    = !rx_dir && !cfg_q.cont && (max_pkt != '0) && (buf_bytes >= max_pkt);

  cfp_settle #(.SETTLE(SETTLE)) u_settle (
    .clk(clk), .rst(rst), .start(cfg_wr || clr_acc), .cond(cond), .rdy(rdy)
  );

  cfp_bval u_bval (
    .clk(clk), .rst(rst), .wr_one(ctl_wr && ctl_wdata[BIT_VALID]),
    .is_tx(!rx_dir), .full(full), .empty_now(buf_bytes == '0),
    .clr(clr_acc), .valid(valid), .commit(buf_commit)
  );

  cfp_rxlen #(.LW(LW)) u_len (
    .clk(clk), .rst(rst), .load(rx_load), .load_len(rx_len), .rd(rd_acc),
    .wide(cfg_q.wide), .cnt(cfg_q.cnt), .clr(clr_acc), .len_view(len_view)
  );

  assign ctl_rdata    = {valid, 1'b0, rdy, {PAD_W{1'b0}}, (rx_dir ? len_view : '0)};
  assign buf_clr      = clr_q;
  assign buf_clr_isel = clr_isel_q;

  assert_clr_gate_R4: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && ctl_wdata[BIT_CLR] && cfg_q.pipe != '0 && !rdy) |=> !buf_clr);
  assert_clr_then_blank_R3: assert property (@(posedge clk) disable iff (rst)
    buf_clr |-> !rdy);
endmodule

// File: tb/sim_cfifo_port_ctrl.sv
module sim_cfifo_port_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 0, cfg_isel = 0, cfg_cnt = 0, cfg_wide = 0, cfg_cont = 0;
  logic [2:0]  cfg_pipe = 0;
  logic [7:0]  pipe_is_rx = 8'b0000_0010;
  logic        ctl_wr = 0;
  logic [15:0] ctl_wdata = 0;
  logic [15:0] ctl_rdata;
  logic        dp_rd = 0, rx_load = 0, buf_room = 1;
  logic [9:0]  max_pkt = 10'd64, rx_len = 0, buf_bytes = 10'd20;
  logic        buf_clr, buf_clr_isel, buf_commit;
  int          n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  cfifo_port_ctrl u0 (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_pipe(cfg_pipe), .cfg_isel(cfg_isel),
    .cfg_cnt(cfg_cnt), .cfg_wide(cfg_wide), .cfg_cont(cfg_cont), .pipe_is_rx(pipe_is_rx),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .dp_rd(dp_rd),
    .max_pkt(max_pkt), .rx_load(rx_load), .rx_len(rx_len), .buf_bytes(buf_bytes),
    .buf_room(buf_room), .buf_clr(buf_clr), .buf_clr_isel(buf_clr_isel),
    .buf_commit(buf_commit)
  );

  // {len[27:18], wide[17], cnt[16], reads[15:10], expected[9:0]}
  localparam logic [27:0] VEC [8] = '{
    {10'd10, 1'b0, 1'b1, 6'd3, 10'd7},
    {10'd10, 1'b1, 1'b1, 6'd3, 10'd4},
    {10'd5,  1'b1, 1'b1, 6'd3, 10'd0},
    {10'd5,  1'b1, 1'b1, 6'd2, 10'd1},
    {10'd6,  1'b0, 1'b0, 6'd2, 10'd6},
    {10'd6,  1'b0, 1'b0, 6'd6, 10'd0},
    {10'd4,  1'b1, 1'b0, 6'd2, 10'd0},
    {10'd7,  1'b1, 1'b0, 6'd3, 10'd7}
  };

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic cfg(input int p, input bit isel, input bit cnt, input bit wide, input bit cont);
    cfg_pipe = 3'(p); cfg_isel = isel; cfg_cnt = cnt; cfg_wide = wide; cfg_cont = cont;
    cfg_wr = 1; @(negedge clk); cfg_wr = 0;
  endtask

  task automatic ctl(input logic [15:0] w);
    ctl_wdata = w; ctl_wr = 1; @(negedge clk); ctl_wr = 0; ctl_wdata = 0;
  endtask

  task automatic load(input int n);
    rx_len = 10'(n); rx_load = 1; @(negedge clk); rx_load = 0;
  endtask

  task automatic reads(input int n);
    if (n > 0) begin
      dp_rd = 1; repeat (n) @(negedge clk); dp_rd = 0;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset word", ctl_rdata, 0);
    chk("R1 reset clr", {buf_clr, buf_commit}, 0);
    rst = 0;

    // R8 R9 table walk on receive pipe 1
    for (int i = 0; i < 8; i++) begin
      cfg(1, 0, VEC[i][16], VEC[i][17], 0);
      repeat (2) @(negedge clk);
      load(VEC[i][27:18]);
      reads(VEC[i][15:10]);
      chk(VEC[i][16] ? "R8 count length" : "R9 held length", ctl_rdata[9:0], VEC[i][9:0]);
    end

    // R3 ready settle after pipe change
    cfg(1, 0, 1, 0, 0);
    chk("R3 blank 1", ctl_rdata[13], 0);
    @(negedge clk); chk("R3 blank 2", ctl_rdata[13], 0);
    @(negedge clk); chk("R3 ready rx", ctl_rdata[13], 1);
    chk("R1 reserved zero", {ctl_rdata[15:14], ctl_rdata[12:10]}, 0);

    // R11 reads ignored while not ready
    buf_bytes = 0; @(negedge clk);
    chk("R3 rx empty not ready", ctl_rdata[13], 0);
    load(8); reads(3);
    chk("R11 ignored reads", ctl_rdata[9:0], 8);
    buf_bytes = 20;

    // R10 R2 direction and length validity
    cfg(2, 0, 1, 0, 0);
    chk("R10 tx pipe len", ctl_rdata[9:0], 0);
    cfg(0, 0, 1, 0, 0);
    chk("R2 pipe0 isel0 len", ctl_rdata[9:0], 0);
    cfg(0, 1, 1, 0, 0);
    chk("R2 pipe0 isel1 len", ctl_rdata[9:0], 8);
    load(12);
    chk("R12 reload", ctl_rdata[9:0], 12);

    // R5 R6 R7 on transmit pipe 2
    cfg(2, 0, 0, 0, 0);
    repeat (2) @(negedge clk);
    chk("R3 ready tx", ctl_rdata[13], 1);
    ctl(16'h8000);
    chk("R5 commit pulse", buf_commit, 1);
    chk("R5 valid set", ctl_rdata[15], 1);
    ctl(16'h8000);
    chk("R5 recommit blocked", buf_commit, 0);
    ctl(16'h0000);
    chk("R5 write 0 keeps", ctl_rdata[15], 1);
    chk("R4 write 0 no clear", buf_clr, 0);
    buf_bytes = 0; @(negedge clk);
    chk("R7 drained", ctl_rdata[15], 0);
    buf_bytes = 64; @(negedge clk);
    chk("R6 full sets", ctl_rdata[15], 1);
    buf_bytes = 20; @(negedge clk);
    ctl(16'h4000);
    chk("R4 clear accepted", buf_clr, 1);
    chk("R7 clear drops valid", ctl_rdata[15], 0);

    // R6 continuous mode does not auto-set
    cfg(2, 0, 0, 0, 1);
    buf_bytes = 64; repeat (3) @(negedge clk);
    chk("R6 cont no set", ctl_rdata[15], 0);
    buf_bytes = 20;

    // R4 clear refused when not ready on pipe 2
    buf_room = 0; repeat (3) @(negedge clk);
    chk("R3 tx no room", ctl_rdata[13], 0);
    ctl(16'h4000);
    chk("R4 clear refused", buf_clr, 0);

    // R4 pipe 0 clear regardless of ready
    buf_bytes = 0;
    cfg(0, 1, 1, 0, 0);
    repeat (2) @(negedge clk);
    chk("R3 pipe0 rx empty", ctl_rdata[13], 0);
    ctl(16'h4000);
    chk("R4 pipe0 clear", buf_clr, 1);
    chk("R4 pipe0 isel", buf_clr_isel, 1);

    summary();
  end
endmodule